// File: doc/BRIEF.md
# Clock Output Stop Gating

This block sits between the clock sources of a clock generator and its output pins, and decides which clocks reach the pins. It takes three source clocks: a CPU clock, a PCI clock and a buffered SDRAM clock. It also takes four active-low stop requests. The source clocks arrive as waveforms sampled by a fast fabric clock `clk`. Each group of outputs has a set of stoppable copies and one or more copies that keep running.

A global stop request removes every output except the differential CPU pair. It acts at once and without a clock edge, so a pulse that is in progress is cut short. The CPU, PCI and SDRAM stop requests each remove only their own stoppable copies, and each one spares the free-running output of its group. These three requests pass through a synchronizer. The enable they drive is only allowed to change while the matching source clock is low, so gating never creates a short pulse.

Top module: `clkstop_gate`

## Requirements
- R1: `cpu_t_o` always equals `cpu_clk_i` and `cpu_c_o` always equals its complement. No stop input and no reset affects either output.
- R2: While `stopclk_n_i` is 0, the outputs `cpu_cs_o`, `pci_o`, `pci_free_o`, `sdram_o` and `sdram_free_o` are all 0. This takes effect in the same time step as the input change, with no clock edge needed, even in the middle of a high phase.
- R3: `cpu_cs_o` equals `cpu_clk_i` ANDed with the CPU enable and with `stopclk_n_i`, so it is in phase with `cpu_t_o`. When the CPU enable is 0, it is held at 0.
- R4: Each bit of `pci_o` equals `pci_clk_i` ANDed with the PCI enable and with `stopclk_n_i`. `pci_free_o` equals `pci_clk_i` ANDed with `stopclk_n_i` only, and is never affected by `pci_stop_n_i`.
- R5: Each bit of `sdram_o` equals `sdram_clk_i` ANDed with the SDRAM enable and with `stopclk_n_i`. `sdram_free_o` equals `sdram_clk_i` ANDed with `stopclk_n_i` and ignores `sdram_stop_n_i`.
- R6: Each domain enable loads, at a rising edge of `clk`, the value its stop input had two rising edges earlier (two synchronizer flops). It loads only if the domain's source clock is 0 at that edge; otherwise the enable holds its value.
- R7: While a domain's source clock stays 1 across consecutive edges and `stopclk_n_i` stays 1, that domain's stoppable outputs do not change. This means there are no runt pulses from the individual stops.
- R8: Reset is synchronous and active high. It clears both synchronizer stages and the enable of every domain to the stopped state, so the stoppable outputs are 0 during reset and just after it.
- R9: All bits of `pci_o` are identical, and all bits of `sdram_o` are identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples the stop requests |
| rst | input | 1 | Synchronous active-high reset |
| cpu_clk_i | input | 1 | CPU source clock waveform |
| pci_clk_i | input | 1 | PCI source clock waveform |
| sdram_clk_i | input | 1 | Buffered SDRAM source clock waveform |
| stopclk_n_i | input | 1 | Global stop, active low, acts without a clock edge |
| cpu_stop_n_i | input | 1 | CPU stop request, active low |
| pci_stop_n_i | input | 1 | PCI stop request, active low |
| sdram_stop_n_i | input | 1 | SDRAM stop request, active low |
| cpu_t_o | output | 1 | Free-running CPU pair, true side |
| cpu_c_o | output | 1 | Free-running CPU pair, complement side |
| cpu_cs_o | output | 1 | Stoppable CPU clock for the chipset |
| pci_o | output | N_PCI | Stoppable PCI copies |
| pci_free_o | output | 1 | PCI copy stopped only by the global stop |
| sdram_o | output | N_SDRAM | Stoppable SDRAM copies |
| sdram_free_o | output | 1 | SDRAM copy stopped only by the global stop |

## Verification
The three source clocks run at three different half-periods (one, two and three `clk` cycles). The enable-load rule therefore sees a different source phase in each domain, which separates an enable that waits for a low source clock from one that updates at every edge. The stimulus is as follows:
- Each individual stop is dropped alone, and then several are dropped together. This separates a stop that reaches only its own group from one that leaks into a free-running output or into another domain.
- One-cycle stop pulses check the two-edge synchronizer delay against a one- or three-stage chain.
- The global stop is pulled low in the middle of a high phase and checked before the next edge. This confirms that it acts asynchronously rather than through a register.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  localparam int NUM_DOM         = 3;
  localparam int DOM_CPU         = 0;
  localparam int DOM_PCI         = 1;
  localparam int DOM_SDR         = 2;
  localparam int DEF_SYNC_STAGES = 2;
  localparam int DEF_N_PCI       = 6;
  localparam int DEF_N_SDRAM     = 6;
endpackage

// File: rtl/clkstop_sync.sv
// Stop request synchronizer plus a low-phase-only enable register.
module clkstop_sync #(
  parameter int STAGES = clkstop_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic src_i,
  input  logic stop_n_i,
  output logic en_o
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= stop_n_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], stop_n_i};
      end
    end
  endgenerate

  // enable only moves while the source clock is low: no truncated pulses
  always_ff @(posedge clk) begin
    if (rst)         en_o <= 1'b0;
    else if (!src_i) en_o <= chain_q[TOP];
  end
endmodule

// File: rtl/clkstop_fanout.sv
// N identical gated copies of one source clock.
module clkstop_fanout #(
  parameter int N = 1
) (
  input  logic         src_i,
  input  logic         en_i,
  input  logic         run_i,
  output logic [N-1:0] out_o
);
  logic gated;
  assign gated = src_i & en_i & run_i;

  generate
    for (genvar g = 0; g < N; g++) begin : g_copy
      assign out_o[g] = gated;
    end
  endgenerate
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter int N_PCI       = DEF_N_PCI,
  parameter int N_SDRAM     = DEF_N_SDRAM,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_clk_i,
  input  logic               pci_clk_i,
  input  logic               sdram_clk_i,
  input  logic               stopclk_n_i,
  input  logic               cpu_stop_n_i,
  input  logic               pci_stop_n_i,
  input  logic               sdram_stop_n_i,
  output logic               cpu_t_o,
  output logic               cpu_c_o,
  output logic               cpu_cs_o,
  output logic [N_PCI-1:0]   pci_o,
  output logic               pci_free_o,
  output logic [N_SDRAM-1:0] sdram_o,
  output logic               sdram_free_o
);
  logic [NUM_DOM-1:0] src_v;
  logic [NUM_DOM-1:0] stop_v;
  logic [NUM_DOM-1:0] en_v;
  logic [0:0]         cs_v;
  logic [0:0]         pfree_v;
  logic [0:0]         sfree_v;

  assign src_v[DOM_CPU]  = cpu_clk_i;
  assign src_v[DOM_PCI]  = pci_clk_i;
  assign src_v[DOM_SDR]  = sdram_clk_i;
  assign stop_v[DOM_CPU] = cpu_stop_n_i;
  assign stop_v[DOM_PCI] = pci_stop_n_i;
  assign stop_v[DOM_SDR] = sdram_stop_n_i;

  generate
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .src_i    (src_v[d]),
        .stop_n_i (stop_v[d]),
        .en_o     (en_v[d])
      );
    end
  endgenerate

  // differential pair bypasses every stop
  assign cpu_t_o = cpu_clk_i;
  assign cpu_c_o = ~cpu_clk_i;

  clkstop_fanout #(.N(1)) u_cs (
    .src_i (cpu_clk_i), .en_i (en_v[DOM_CPU]), .run_i (stopclk_n_i), .out_o (cs_v)
  );
  clkstop_fanout #(.N(N_PCI)) u_pci (
    .src_i (pci_clk_i), .en_i (en_v[DOM_PCI]), .run_i (stopclk_n_i), .out_o (pci_o)
  );
  clkstop_fanout #(.N(1)) u_pci_free (
    .src_i (pci_clk_i), .en_i (1'b1), .run_i (stopclk_n_i), .out_o (pfree_v)
  );
  clkstop_fanout #(.N(N_SDRAM)) u_sdram (
    .src_i (sdram_clk_i), .en_i (en_v[DOM_SDR]), .run_i (stopclk_n_i), .out_o (sdram_o)
  );
  clkstop_fanout #(.N(1)) u_sdram_free (
    .src_i (sdram_clk_i), .en_i (1'b1), .run_i (stopclk_n_i), .out_o (sfree_v)
  );

  assign cpu_cs_o     = cs_v[0];
  assign pci_free_o   = pfree_v[0];
  assign sdram_free_o = sfree_v[0];
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk #(
  parameter int N_PCI   = 6,
  parameter int N_SDRAM = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               cpu_clk_i,
  input logic               pci_clk_i,
  input logic               sdram_clk_i,
  input logic               stopclk_n_i,
  input logic               cpu_t_o,
  input logic               cpu_c_o,
  input logic               cpu_cs_o,
  input logic [N_PCI-1:0]   pci_o,
  input logic               pci_free_o,
  input logic [N_SDRAM-1:0] sdram_o,
  input logic               sdram_free_o
);
  p_pair_r1: assert property (@(posedge clk) cpu_c_o == ~cpu_t_o);

  p_global_low_r2: assert property (@(posedge clk) disable iff (rst)
    !stopclk_n_i |-> (!cpu_cs_o && pci_o == '0 && !pci_free_o && sdram_o == '0 && !sdram_free_o));

  p_cs_phase_r3: assert property (@(posedge clk) cpu_cs_o |-> cpu_t_o);

  p_pci_free_r4: assert property (@(posedge clk) (pci_o != '0) |-> pci_free_o);

  p_sdram_free_r5: assert property (@(posedge clk) (sdram_o != '0) |-> sdram_free_o);

  p_no_runt_cpu_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_i && $past(cpu_clk_i) && stopclk_n_i && $past(stopclk_n_i)) |-> $stable(cpu_cs_o));

  p_no_runt_pci_r7: assert property (@(posedge clk) disable iff (rst)
    (pci_clk_i && $past(pci_clk_i) && stopclk_n_i && $past(stopclk_n_i)) |-> $stable(pci_o));

  p_no_runt_sdram_r7: assert property (@(posedge clk) disable iff (rst)
    (sdram_clk_i && $past(sdram_clk_i) && stopclk_n_i && $past(stopclk_n_i)) |-> $stable(sdram_o));

  p_reset_stopped_r8: assert property (@(posedge clk)
    rst |=> (!cpu_cs_o && pci_o == '0 && sdram_o == '0));

  p_copies_r9: assert property (@(posedge clk)
    (pci_o == '0 || pci_o == '1) && (sdram_o == '0 || sdram_o == '1));
endmodule

bind clkstop_gate clkstop_chk #(.N_PCI(N_PCI), .N_SDRAM(N_SDRAM)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_clk_i    (cpu_clk_i),
  .pci_clk_i    (pci_clk_i),
  .sdram_clk_i  (sdram_clk_i),
  .stopclk_n_i  (stopclk_n_i),
  .cpu_t_o      (cpu_t_o),
  .cpu_c_o      (cpu_c_o),
  .cpu_cs_o     (cpu_cs_o),
  .pci_o        (pci_o),
  .pci_free_o   (pci_free_o),
  .sdram_o      (sdram_o),
  .sdram_free_o (sdram_free_o)
);

// File: tb/test_clkstop_gate.sv
module test_clkstop_gate;
  localparam int NP = 6;
  localparam int NS = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic cpu_ck = 1'b0, pci_ck = 1'b0, sdr_ck = 1'b0;
  logic gstop_n = 1'b1, cstop_n = 1'b1, pstop_n = 1'b1, sstop_n = 1'b1;
  logic cpu_t, cpu_c, cpu_cs, pci_free, sdram_free;
  logic [NP-1:0] pci;
  logic [NS-1:0] sdram;

  clkstop_gate #(.N_PCI(NP), .N_SDRAM(NS)) i_clkstop_gate (
    .clk (clk), .rst (rst),
    .cpu_clk_i (cpu_ck), .pci_clk_i (pci_ck), .sdram_clk_i (sdr_ck),
    .stopclk_n_i (gstop_n), .cpu_stop_n_i (cstop_n),
    .pci_stop_n_i (pstop_n), .sdram_stop_n_i (sstop_n),
    .cpu_t_o (cpu_t), .cpu_c_o (cpu_c), .cpu_cs_o (cpu_cs),
    .pci_o (pci), .pci_free_o (pci_free),
    .sdram_o (sdram), .sdram_free_o (sdram_free)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  // reference model: stop history queues, enables loaded when source is low
  bit q_cpu[$], q_pci[$], q_sdr[$];
  bit m_cpu = 0, m_pci = 0, m_sdr = 0;

  always @(posedge clk) begin
    bit o;
    if (rst) begin
      q_cpu = {1'b0, 1'b0}; q_pci = {1'b0, 1'b0}; q_sdr = {1'b0, 1'b0};
      m_cpu = 0; m_pci = 0; m_sdr = 0;
    end else begin
      o = q_cpu.pop_front(); q_cpu.push_back(cstop_n); if (!cpu_ck) m_cpu = o;
      o = q_pci.pop_front(); q_pci.push_back(pstop_n); if (!pci_ck) m_pci = o;
      o = q_sdr.pop_front(); q_sdr.push_back(sstop_n); if (!sdr_ck) m_sdr = o;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cyc=%0d act=%h exp=%h", tag, cyc, act, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] e_pci, e_sdr;
    string g;
    g = gstop_n ? "" : " R2";
    e_pci = {32{pci_ck & m_pci & gstop_n}} & ((32'd1 << NP) - 1);
    e_sdr = {32{sdr_ck & m_sdr & gstop_n}} & ((32'd1 << NS) - 1);
    chk("R1 cpu_t", {31'd0, cpu_t}, {31'd0, cpu_ck});
    chk("R1 cpu_c", {31'd0, cpu_c}, {31'd0, ~cpu_ck});
    chk({"R3 R6 R7 R8 cpu_cs", g}, {31'd0, cpu_cs}, {31'd0, cpu_ck & m_cpu & gstop_n});
    chk({"R4 R6 R9 pci", g}, {{(32-NP){1'b0}}, pci}, e_pci);
    chk({"R4 pci_free", g}, {31'd0, pci_free}, {31'd0, pci_ck & gstop_n});
    chk({"R5 R6 R9 sdram", g}, {{(32-NS){1'b0}}, sdram}, e_sdr);
    chk({"R5 sdram_free", g}, {31'd0, sdram_free}, {31'd0, sdr_ck & gstop_n});
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      cpu_ck = cyc[0];
      pci_ck = ((cyc / 2) % 2) == 1;
      sdr_ck = ((cyc / 3) % 2) == 1;
      #1 compare();
    end
  endtask

  // drop the global stop mid high phase and check before any edge (R2)
  task automatic mid_cut();
    for (int i = 0; i < 12; i++) begin
      run(1);
      if (cpu_ck && pci_ck && sdr_ck) begin
        #1 gstop_n = 1'b0;
        #1 compare();
        gstop_n = 1'b1;
        #1 compare();
        return;
      end
    end
  endtask

  initial begin
    run(4);            // R8: reset holds stoppable outputs low
    rst = 1'b0;
    run(12);
    pstop_n = 1'b0; run(14); pstop_n = 1'b1; run(8);      // R4
    sstop_n = 1'b0; run(14); sstop_n = 1'b1; run(8);      // R5
    cstop_n = 1'b0; run(10); cstop_n = 1'b1; run(8);      // R3
    cstop_n = 1'b0; pstop_n = 1'b0; sstop_n = 1'b0; run(12);
    cstop_n = 1'b1; pstop_n = 1'b1; sstop_n = 1'b1; run(10);
    for (int k = 0; k < 6; k++) begin                     // R6 one-cycle pulses
      pstop_n = 1'b0; sstop_n = (k % 2) == 1; cstop_n = 1'b0; run(1);
      pstop_n = 1'b1; sstop_n = 1'b1; cstop_n = 1'b1; run(1 + k);
    end
    gstop_n = 1'b0; run(10); gstop_n = 1'b1; run(6);      // R2
    mid_cut();
    mid_cut();
    rst = 1'b1; run(3); rst = 1'b0; run(8);               // R8 again
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule